// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes six external interrupt pins and turns them into a single prioritised request to the CPU. Each pin has an 8-bit control register and a per-pin both-edges enable. The control register sets a priority from 0 to 7, a trigger polarity and a choice between edge and level detection. When its trigger condition occurs, a pin sets a pending flag. Software can only clear this flag. The CPU clears it by acknowledging the source.

A pending source is eligible only when its level is non-zero and strictly above the CPU's current priority level. Among the eligible sources, the highest level wins, and a tie goes to the lowest pin index. The block drives the request line, the winning index and the winning level from registers. The CPU acknowledges by returning the index of the source it accepted. Each pin passes through a two-flop synchroniser before detection, so a pin change reaches its pending flag on the third rising clock edge after the change.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every readable register (addresses 0 to 6) reads 0 and `irq_req` is 0.
- R2: A source whose priority field (control bits 2:0) is 0 never raises `irq_req`, even while its pending flag is set.
- R3: A pending source with a non-zero level raises `irq_req` only when its level is strictly greater than `cpu_ipl`. `irq_lvl` then equals that level.
- R4: The pending flag is control bit 3. It is set by the pin's trigger condition. An acknowledge whose `ack_idx` names the source clears it, and an acknowledge naming any other index leaves it unchanged.
- R5: A register write with bit 3 at 0 clears the pending flag. A write with bit 3 at 1 leaves the flag unchanged.
- R6: In edge mode (control bit 5 = 0), polarity bit 4 = 1 triggers on a rising edge and bit 4 = 0 on a falling edge. The opposite edge does not set the flag.
- R7: In level mode (bit 5 = 1), the flag is set on every cycle in which the pin is at the active level (high when bit 4 = 1). A software clear while the pin stays active is immediately overridden, and a clear sticks once the pin is inactive.
- R8: Address 6 holds the both-edges enables, bit i for source i, and reads back as written. With its bit set and edge mode selected, a source triggers on both rising and falling edges.
- R9: Control bits 7:6 are unimplemented. Writes to them are ignored, and they read as 0.
- R10: When several eligible sources are pending, `irq_idx` and `irq_lvl` name the one with the highest level. Ties go to the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 6 | Raw asynchronous interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0-5 control, 6 both-edges enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cpu_ipl | input | 3 | CPU current priority level |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_idx | input | 3 | Index of the acknowledged source |
| irq_req | output | 1 | Registered interrupt request |
| irq_idx | output | 3 | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
The assertions assume that `ack_valid` names an index in the range 0 to 5 and that the both-edges enable is used only with polarity 0 in edge mode. They also assume that `cpu_ipl` is held for at least one cycle before `irq_req` is judged against it. The stimulus changes pins only at negative clock edges and holds each pin level for several cycles. It acknowledges only valid indices and keeps the both-edges source at polarity 0. The priority sweep changes `cpu_ipl` and the level field together, then waits several cycles before it samples the request.

// File: rtl/eirq_pkg.sv
// Package: shared constants for the external interrupt request controller.
// Assumes: 8-bit control registers, 3-bit priority levels.
package eirq_pkg;
    localparam int LVL_W      = 3;
    localparam int REG_W      = 8;
    localparam int BIT_PEND   = 3;
    localparam int BIT_POL    = 4;
    localparam int BIT_LVLMOD = 5;
endpackage

// File: rtl/irq_pin_detect.sv
// Module: irq_pin_detect
// Synchronises one raw pin through two flops and produces a one-cycle
// trigger for the selected edge, or a continuous trigger in level mode.
// Assumes: dual-edge is used only with edge mode; level mode takes precedence.
module irq_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic lvl_mode,
    input  logic dual,
    output logic trig
);
    logic s1_q, s2_q, prev_q;

    // Two-flop synchroniser followed by a one-cycle history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    logic changed;
    // Decode the configured trigger condition from the synchronised value.
    always_comb begin
        changed = s2_q ^ prev_q;
        if (lvl_mode)
            trig = (s2_q == pol);
        else if (dual)
            trig = changed;
        else
            trig = changed && (s2_q == pol);
    end
endmodule

// File: rtl/irq_src_reg.sv
// Module: irq_src_reg
// Holds one source's control register: priority, polarity, mode and the
// pending flag. A hardware trigger wins over any clear in the same cycle.
// Assumes: wr_sel is asserted only when this source's address is written.
module irq_src_reg
    import eirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             trig,
    input  logic             ack_hit,
    output logic [LVL_W-1:0] prio,
    output logic             pol,
    output logic             lvl_mode,
    output logic             pend
);
    // Configuration fields: loaded on write, bits 7:6 dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio     <= '0;
            pol      <= 1'b0;
            lvl_mode <= 1'b0;
        end else if (wr_sel) begin
            prio     <= wdata[LVL_W-1:0];
            pol      <= wdata[BIT_POL];
            lvl_mode <= wdata[BIT_LVLMOD];
        end
    end

    // Pending flag: set by trigger, cleared by acknowledge or by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (trig)
            pend <= 1'b1;
        else if (ack_hit)
            pend <= 1'b0;
        else if (wr_sel && !wdata[BIT_PEND])
            pend <= 1'b0;
    end

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !trig) |=> !pend);

    assert_write_one_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[BIT_PEND] && !trig && !ack_hit) |=> (pend == $past(pend)));
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Picks the pending source with the highest level strictly above the CPU
// level; ties go to the lowest index. Outputs are registered.
// Assumes: prio_flat packs LVL_W bits per source, source 0 lowest.
module irq_arbiter
    import eirq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       pend_vec,
    input  logic [NUM_SRC*LVL_W-1:0] prio_flat,
    input  logic [LVL_W-1:0]         cpu_ipl,
    output logic                     irq_req,
    output logic [IDX_W-1:0]         irq_idx,
    output logic [LVL_W-1:0]         irq_lvl
);
    logic             found;
    logic [IDX_W-1:0] best_idx;
    logic [LVL_W-1:0] best_lvl;

    // Scan sources in ascending order; strict compare keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_vec[i] && (prio_flat[i*LVL_W +: LVL_W] > cpu_ipl)
                && (prio_flat[i*LVL_W +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_lvl = prio_flat[i*LVL_W +: LVL_W];
            end
        end
    end

    // Register the decision towards the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_idx <= '0;
            irq_lvl <= '0;
        end else begin
            irq_req <= found;
            irq_idx <= best_idx;
            irq_lvl <= best_lvl;
        end
    end

    assert_req_level_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != '0));

    assert_req_above_ipl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > $past(cpu_ipl)));
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: ext_irq_ctrl (top)
// External interrupt request controller: per-pin detection and control
// registers, a both-edges enable register at address NUM_SRC, and a
// priority arbiter towards the CPU.
// Assumes: NUM_SRC <= 8 so the enable register fits one data word.
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_SRC = 6,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ext_pin,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [LVL_W-1:0]   cpu_ipl,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_idx,
    output logic [LVL_W-1:0]   irq_lvl
);
    logic [NUM_SRC-1:0]       dual_q;
    logic [NUM_SRC-1:0]       pend_vec;
    logic [NUM_SRC*LVL_W-1:0] prio_flat;
    logic [REG_W-1:0]         ctrl_rd [NUM_SRC];

    // Both-edges enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dual_q <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(NUM_SRC))
            dual_q <= reg_wdata[NUM_SRC-1:0];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic             trig;
        logic             pol;
        logic             lvl_mode;
        logic [LVL_W-1:0] prio;

        irq_pin_detect det_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (ext_pin[g]),
            .pol      (pol),
            .lvl_mode (lvl_mode),
            .dual     (dual_q[g]),
            .trig     (trig)
        );

        irq_src_reg reg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (reg_wr && reg_addr == ADDR_W'(g)),
            .wdata    (reg_wdata),
            .trig     (trig),
            .ack_hit  (ack_valid && ack_idx == IDX_W'(g)),
            .prio     (prio),
            .pol      (pol),
            .lvl_mode (lvl_mode),
            .pend     (pend_vec[g])
        );

        assign prio_flat[g*LVL_W +: LVL_W] = prio;
        assign ctrl_rd[g] = {2'b00, lvl_mode, pol, pend_vec[g], prio};
    end

    // Read multiplexer over control registers and the enable register.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (reg_addr == ADDR_W'(i))
                reg_rdata = ctrl_rd[i];
        if (reg_addr == ADDR_W'(NUM_SRC))
            for (int j = 0; j < NUM_SRC; j++)
                reg_rdata[j] = dual_q[j];
    end

    irq_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_vec  (pend_vec),
        .prio_flat (prio_flat),
        .cpu_ipl   (cpu_ipl),
        .irq_req   (irq_req),
        .irq_idx   (irq_idx),
        .irq_lvl   (irq_lvl)
    );
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ext_pin = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] cpu_ipl = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic [2:0] irq_lvl;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_ipl(cpu_ipl), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_lvl(irq_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 v = int'(reg_rdata);
    endtask

    task automatic ack(input int i);
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = 3'(i);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int i);
        ext_pin[i] = 1'b1; waitc(5);
        ext_pin[i] = 1'b0; waitc(5);
    endtask

    task automatic chk_req(input string req, input int r, input int idx, input int lvl);
        waitc(3);
        chk(req, int'(irq_req), r);
        if (r != 0) begin
            chk(req, int'(irq_idx), idx);
            chk(req, int'(irq_lvl), lvl);
        end
    endtask

    initial begin
        int v;
        waitc(3);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(a, v); chk("R1", v, 0);
        end
        chk("R1", int'(irq_req), 0);

        // R9: bits 7:6 ignored
        wr(0, 8'hC0); rd(0, v); chk("R9", v, 8'h00);
        wr(0, 8'hFF); rd(0, v); chk("R9", v, 8'h37);
        wr(0, 8'h00);

        // R6: rising edge with polarity 1
        wr(0, 8'h19);
        ext_pin[0] = 1'b1; waitc(5);
        rd(0, v); chk("R6", v, 8'h19);
        chk_req("R10", 1, 0, 1);
        ext_pin[0] = 1'b0; waitc(5);
        // R5: write 0 to bit 3 clears
        wr(0, 8'h11); rd(0, v); chk("R5", v, 8'h11);
        // R6: polarity 0 ignores rising, sets on falling
        wr(0, 8'h01);
        ext_pin[0] = 1'b1; waitc(5);
        rd(0, v); chk("R6", v, 8'h01);
        ext_pin[0] = 1'b0; waitc(5);
        rd(0, v); chk("R6", v, 8'h09);
        // R5: write 1 to bit 3 keeps
        wr(0, 8'h09); rd(0, v); chk("R5", v, 8'h09);
        // R4: acknowledge clears
        ack(0); rd(0, v); chk("R4", v, 8'h01);

        // R4: acknowledge of another index leaves the flag
        wr(1, 8'h11); pulse(1);
        rd(1, v); chk("R4", v, 8'h19);
        ack(2); rd(1, v); chk("R4", v, 8'h19);
        ack(1); rd(1, v); chk("R4", v, 8'h11);
        wr(1, 8'h10);

        // R2/R3: sweep level against CPU level
        wr(0, 8'h11); pulse(0);
        for (int lvl = 0; lvl < 8; lvl++) begin
            for (int ipl = 0; ipl < 8; ipl++) begin
                cpu_ipl = 3'(ipl);
                wr(0, 8'h18 | lvl);
                chk_req((lvl == 0) ? "R2" : "R3", (lvl != 0 && lvl > ipl) ? 1 : 0, 0, lvl);
            end
        end
        cpu_ipl = '0;
        ack(0); wr(0, 8'h10);

        // R7: level mode high-active
        wr(2, 8'h3A);
        ext_pin[2] = 1'b1; waitc(5);
        rd(2, v); chk("R7", v, 8'h3A);
        wr(2, 8'h32); waitc(3);
        rd(2, v); chk("R7", v, 8'h3A);
        ext_pin[2] = 1'b0; waitc(5);
        wr(2, 8'h32); waitc(5);
        rd(2, v); chk("R7", v, 8'h32);
        wr(2, 8'h30);

        // R8: both-edges enable
        wr(6, 8'h08); rd(6, v); chk("R8", v, 8'h08);
        wr(3, 8'h0B);
        ext_pin[3] = 1'b1; waitc(5);
        rd(3, v); chk("R8", v, 8'h0B);
        wr(3, 8'h03);
        ext_pin[3] = 1'b0; waitc(5);
        rd(3, v); chk("R8", v, 8'h0B);
        wr(3, 8'h00); wr(6, 8'h00);

        // R10: arbitration among several pending sources
        wr(1, 8'h1D); wr(4, 8'h1D); wr(5, 8'h1F);
        pulse(5); pulse(4); pulse(1);
        chk_req("R10", 1, 5, 7);
        ack(5); chk_req("R10", 1, 1, 5);
        ack(1); chk_req("R10", 1, 4, 5);
        cpu_ipl = 3'd5; chk_req("R3", 0, 0, 0);
        cpu_ipl = 3'd4; chk_req("R3", 1, 4, 5);
        ack(4); chk_req("R4", 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule